// File: doc/BRIEF.md
# Chip-Select Decoder with Dual-Bus Mapping

This block turns an active-low slave-select field into the individual active-low chip-select lines of one or two parallel serial-flash buses. A zero bit in the field requests a slave. When several bits are zero, only the lowest-numbered requested slave is driven, and that one slave is mirrored onto every effective bus. An upper-page control bit shifts every driven line index up by one, wrapping around the configured line count. This lets a single logical select land on the neighbouring device.

The field and the mapping controls are sampled on a write strobe. The chip-select lines are registered and change on the clock edge that takes the write. When a write requests no slave at all, the block releases every line and gives a one-cycle strobe. A downstream command snooper uses that strobe to return to its checking state.

Top module: `cs_decoder`

## Requirements
- R1: While reset is asserted and after it is released, every bit of `csN` is 1 and `noneSel` is 0 until the first write.
- R2: On a write, only the lowest index i with `selField[i]==0` is selected, and each effective bus drives exactly one line low for it. Example: field 4'b0011 in single-bus mode gives `csN==8'hFB`.
- R3: Inputs are sampled only on a clock edge where `wrEn` is 1, and the result shows after that edge. Without a write, `csN` holds its value whatever the other inputs do.
- R4: The number of effective buses equals the configured bus count only when `sepBus` and `twoMem` are both 1. Otherwise it is one, and at most one line goes low.
- R5: With `upPage` at 0, slave i on bus j drives line index j*NUM_CS+i. Example: slave 1 on two effective buses gives `csN==8'hDD`.
- R6: With `upPage` at 1, the line index is (j*NUM_CS+i+1) mod (NUM_CS*busCount). Examples: slave 3 with bus count 1 gives `8'hFE`. Slave 3 on two effective buses gives `8'hEE`. Slave 3 with bus count 2 and one effective bus gives `8'hEF`.
- R7: A write whose field has no zero bit drives all lines high and raises `noneSel` for exactly the cycle after that write.
- R8: Line indices at or above NUM_CS*busCount are always 1. Example: with bus count 1, `csN[7:4]==4'hF`.
- R9: A bus count of 0 is treated as 1, and a bus count above MAX_BUSES is treated as MAX_BUSES. Examples: slave 2, both flags set, count 0 gives `8'hFB`; count 3 gives `8'hBB`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe; samples all control inputs |
| selField | input | NUM_CS (4) | Active-low slave request field |
| twoMem | input | 1 | Two memories attached |
| sepBus | input | 1 | Memories on separate buses |
| upPage | input | 1 | Upper-page rotation by one line |
| busCount | input | $clog2(MAX_BUSES+1) (2) | Configured bus count |
| csN | output | NUM_CS*MAX_BUSES (8) | Active-low chip selects, index bus*NUM_CS+slave |
| noneSel | output | 1 | One-cycle strobe: last write selected nobody |

## Verification
Fields with several zero bits show whether the priority picks the lowest index rather than the highest or several lines. Setting only one of the two bus flags, then both, separates the single-bus mapping from the mirrored one. The upper-page cases use slave 3, so the modulo wrap shows up both with one bus and with two. Bus counts of 0 and 3 expose the clamping. An all-ones field and a hold period without a write check the strobe timing and whether the output holds.

// File: rtl/cs_decoder_pkg.sv
package cs_decoder_pkg;
  localparam int CTL_W = 8;

  typedef struct packed {
    logic             load;
    logic             anySel;
    logic             upage;
    logic [CTL_W-1:0] selIdx;
    logic [CTL_W-1:0] effBuses;
    logic [CTL_W-1:0] total;
  } csStrobe_t;
endpackage

// File: rtl/cs_decoder_ctrl.sv
module cs_decoder_ctrl
  import cs_decoder_pkg::*;
#(
  parameter int NUM_CS    = 4,
  parameter int MAX_BUSES = 2,
  localparam int BCW      = $clog2(MAX_BUSES + 1)
) (
  input  logic              wrEn,
  input  logic [NUM_CS-1:0] selField,
  input  logic              twoMem,
  input  logic              sepBus,
  input  logic              upPage,
  input  logic [BCW-1:0]    busCount,
  output csStrobe_t         strb
);
  logic [CTL_W-1:0] busClamp;
  logic [CTL_W-1:0] pickIdx;
  logic             pickAny;

  // priority: scan from the top so the lowest zero bit is written last
  always_comb begin
    pickIdx = '0;
    pickAny = 1'b0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (!selField[i]) begin
        pickAny = 1'b1;
        pickIdx = CTL_W'(i);
      end
    end
  end

  always_comb begin
    if (busCount == '0)
      busClamp = CTL_W'(1);
    else if (int'(busCount) > MAX_BUSES)
      busClamp = CTL_W'(MAX_BUSES);
    else
      busClamp = CTL_W'(busCount);
  end

  always_comb begin
    strb.load     = wrEn;
    strb.anySel   = pickAny;
    strb.upage    = upPage;
    strb.selIdx   = pickIdx;
    strb.effBuses = (sepBus && twoMem) ? busClamp : CTL_W'(1);
    strb.total    = CTL_W'(NUM_CS * busClamp);
  end
endmodule

// File: rtl/cs_decoder_datapath.sv
module cs_decoder_datapath
  import cs_decoder_pkg::*;
#(
  parameter int NUM_CS    = 4,
  parameter int MAX_BUSES = 2,
  localparam int LINES    = NUM_CS * MAX_BUSES,
  localparam int IDX_W    = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  csStrobe_t        strb,
  output logic [LINES-1:0] csN,
  output logic             noneSel
);
  logic [MAX_BUSES-1:0] busHit;
  logic [IDX_W-1:0]     busLine [MAX_BUSES];
  logic [LINES-1:0]     nextCsN;

  genvar j;
  generate
    for (j = 0; j < MAX_BUSES; j++) begin : g_bus
      logic [CTL_W-1:0] rawIdx;
      logic [CTL_W-1:0] wrapIdx;
      // raw index never exceeds total, so one subtraction wraps it
      assign rawIdx  = CTL_W'(j * NUM_CS) + strb.selIdx + CTL_W'(strb.upage);
      assign wrapIdx = (rawIdx >= strb.total) ? (rawIdx - strb.total) : rawIdx;
      assign busLine[j] = wrapIdx[IDX_W-1:0];
      assign busHit[j]  = strb.anySel && (CTL_W'(j) < strb.effBuses);
    end
  endgenerate

  always_comb begin
    nextCsN = '1;
    for (int b = 0; b < MAX_BUSES; b++) begin
      if (busHit[b]) nextCsN[busLine[b]] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csN     <= '1;
      noneSel <= 1'b0;
    end else begin
      if (strb.load) csN <= nextCsN;
      noneSel <= strb.load && !strb.anySel;
    end
  end
endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
  import cs_decoder_pkg::*;
#(
  parameter int NUM_CS    = 4,
  parameter int MAX_BUSES = 2,
  localparam int LINES    = NUM_CS * MAX_BUSES,
  localparam int BCW      = $clog2(MAX_BUSES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [NUM_CS-1:0] selField,
  input  logic              twoMem,
  input  logic              sepBus,
  input  logic              upPage,
  input  logic [BCW-1:0]    busCount,
  output logic [LINES-1:0]  csN,
  output logic              noneSel
);
  csStrobe_t strb;

  cs_decoder_ctrl #(.NUM_CS(NUM_CS), .MAX_BUSES(MAX_BUSES)) u_ctrl (
    .wrEn(wrEn), .selField(selField), .twoMem(twoMem), .sepBus(sepBus),
    .upPage(upPage), .busCount(busCount), .strb(strb)
  );

  cs_decoder_datapath #(.NUM_CS(NUM_CS), .MAX_BUSES(MAX_BUSES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .csN(csN), .noneSel(noneSel)
  );
endmodule

// File: rtl/cs_decoder_checker.sv
module cs_decoder_checker #(
  parameter int NUM_CS    = 4,
  parameter int MAX_BUSES = 2,
  localparam int LINES    = NUM_CS * MAX_BUSES,
  localparam int BCW      = $clog2(MAX_BUSES + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [NUM_CS-1:0] selField,
  input logic              twoMem,
  input logic              sepBus,
  input logic [BCW-1:0]    busCount,
  input logic [LINES-1:0]  csN,
  input logic              noneSel
);
  assert_one_per_bus_R2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~csN) <= MAX_BUSES);

  assert_hold_without_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(csN));

  assert_single_bus_one_line_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !(sepBus && twoMem)) |=> ($countones(~csN) <= 1));

  assert_empty_field_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (&selField)) |=> (noneSel && (&csN)));

  assert_strobe_lines_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    noneSel |-> (&csN));

  assert_strobe_needs_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> !noneSel);

  assert_upper_lines_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busCount <= 1) |=> (&csN[LINES-1:NUM_CS]));
endmodule

bind cs_decoder cs_decoder_checker #(.NUM_CS(NUM_CS), .MAX_BUSES(MAX_BUSES)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .selField(selField), .twoMem(twoMem),
  .sepBus(sepBus), .busCount(busCount), .csN(csN), .noneSel(noneSel)
);

// File: tb/cs_decoder_test.sv
module cs_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] selField = 4'hF;
  logic       twoMem = 1'b0;
  logic       sepBus = 1'b0;
  logic       upPage = 1'b0;
  logic [1:0] busCount = 2'd1;
  logic [7:0] csN;
  logic       noneSel;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cs_decoder uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .selField(selField), .twoMem(twoMem),
    .sepBus(sepBus), .upPage(upPage), .busCount(busCount), .csN(csN),
    .noneSel(noneSel)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive one write at a falling edge; results are sampled at the next falling edge
  task automatic doWrite(input logic [3:0] f, input logic [1:0] bc,
                         input logic sep, input logic two, input logic up);
    @(negedge clk);
    selField = f; busCount = bc; sepBus = sep; twoMem = two; upPage = up;
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic testReset();
    check("R1 csN after reset", csN, 8'hFF);
    check("R1 noneSel after reset", {7'b0, noneSel}, 8'h00);
  endtask

  task automatic testPriority();
    doWrite(4'b0011, 2'd1, 1'b0, 1'b0, 1'b0);
    check("R2 lowest zero is slave 2", csN, 8'hFB);
    check("R2 noneSel low", {7'b0, noneSel}, 8'h00);
    doWrite(4'b0100, 2'd1, 1'b0, 1'b0, 1'b0);
    check("R2 lowest zero is slave 0", csN, 8'hFE);
  endtask

  task automatic testHold();
    doWrite(4'b0111, 2'd1, 1'b0, 1'b0, 1'b0);
    check("R3 write slave 3", csN, 8'hF7);
    @(negedge clk);
    selField = 4'b1110; sepBus = 1'b1; twoMem = 1'b1; busCount = 2'd2; upPage = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 held without write", csN, 8'hF7);
  endtask

  task automatic testSingleFlag();
    doWrite(4'b1101, 2'd2, 1'b1, 1'b0, 1'b0);
    check("R4 only separate-bus flag", csN, 8'hFD);
    doWrite(4'b1101, 2'd2, 1'b0, 1'b1, 1'b0);
    check("R4 only two-memory flag", csN, 8'hFD);
  endtask

  task automatic testDual();
    doWrite(4'b1101, 2'd2, 1'b1, 1'b1, 1'b0);
    check("R5 slave 1 mirrored", csN, 8'hDD);
  endtask

  task automatic testRotate();
    doWrite(4'b0111, 2'd1, 1'b0, 1'b0, 1'b1);
    check("R6 single bus wrap", csN, 8'hFE);
    doWrite(4'b0111, 2'd2, 1'b1, 1'b1, 1'b1);
    check("R6 dual bus wrap", csN, 8'hEE);
    doWrite(4'b0111, 2'd2, 1'b0, 1'b0, 1'b1);
    check("R6 one effective bus of two", csN, 8'hEF);
  endtask

  task automatic testNone();
    doWrite(4'b1011, 2'd1, 1'b0, 1'b0, 1'b0);
    doWrite(4'b1111, 2'd1, 1'b0, 1'b0, 1'b0);
    check("R7 all lines high", csN, 8'hFF);
    check("R7 strobe high", {7'b0, noneSel}, 8'h01);
    @(negedge clk);
    check("R7 strobe one cycle", {7'b0, noneSel}, 8'h00);
  endtask

  task automatic testUpper();
    doWrite(4'b1110, 2'd1, 1'b1, 1'b1, 1'b0);
    check("R8 upper lines high", {4'h0, csN[7:4]}, 8'h0F);
    check("R8 full vector", csN, 8'hFE);
  endtask

  task automatic testClamp();
    doWrite(4'b1011, 2'd0, 1'b1, 1'b1, 1'b0);
    check("R9 count zero as one", csN, 8'hFB);
    doWrite(4'b1011, 2'd3, 1'b1, 1'b1, 1'b0);
    check("R9 count three as two", csN, 8'hBB);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testPriority();
    testHold();
    testSingleFlag();
    testDual();
    testRotate();
    testNone();
    testUpper();
    testClamp();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule